// File: doc/BRIEF.md
# Register Access Checker with Status Byte

This block sits behind a packet framer. It carries out the memory-access commands that the framer has already decoded. A request arrives as one header pulse that holds a direction, a 16-bit byte address and a 16-bit byte count. A write request then delivers its data bytes one per cycle and ends with a done pulse. The block screens every request before it touches storage. Accepted requests become 32-bit word operations on a simple register-file port. A read returns only the data bytes, as a byte stream.

The block also keeps the 8-bit sticky status byte. The framer reports its own error events as a bit vector. This block adds its own memory-error events. The whole byte clears when the host reads it.

Top module: `reg_access_status`

## Requirements
- R1: An accepted read of N bytes at address A issues N/4 register reads at A, A+4, and so on. Each word is read back the cycle after its read strobe. The block then emits N data bytes on the response stream, most significant byte of each word first, with no address or length bytes.
- R2: A request whose address is not a multiple of 4 sets status bit 3 (memory error) at the header pulse. It performs no register access.
- R3: A request whose byte count is not a multiple of 4 sets status bit 3. It performs no register access.
- R4: A write whose word range includes any register marked read-only in the RO_MASK parameter sets status bit 3. It writes no word at all, not even the words before the read-only one.
- R5: A write sets status bit 3 and writes nothing when the number of data bytes received before its done pulse differs from the byte count.
- R6: A request that reaches past the last register (address plus count greater than 4·NREGS) sets status bit 3. It performs no access.
- R7: An accepted write performs one word write per cycle, in consecutive cycles, at addresses rising by 4. Data bytes are packed most significant byte first.
- R8: Status bit k is set by evt_in[k]. The bits mean: 0 busy, 1 CRC error, 2 receive error, 3 memory error, 4 nonvolatile-storage error, 5 unknown feature, 6 unknown command, 7 general error. Bit 3 is also set by the block's own rejections.
- R9: A stat_rd pulse clears the whole status byte at that clock edge.
- R10: An event that arrives in the same cycle as stat_rd is set in the byte after the clear.
- R11: A request with a byte count of zero performs no access, emits no bytes and sets no error.
- R12: The read strobe, the write enable and the response-valid output are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Header pulse of a request |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 16 | Byte address of the first word |
| req_len | input | 16 | Byte count N |
| wdat_valid | input | 1 | Write data byte valid |
| wdat_byte | input | 8 | Write data byte |
| req_done | input | 1 | End of a write request's data |
| evt_in | input | 8 | Error events from the framer, one per status bit |
| stat_rd | input | 1 | Host reads the status byte (clear) |
| status | output | 8 | Sticky status byte |
| rsp_valid | output | 1 | Response data byte valid |
| rsp_byte | output | 8 | Response data byte |
| rf_addr | output | 16 | Register byte address |
| rf_wdata | output | 32 | Register write data |
| rf_we | output | 1 | Register write enable |
| rf_rd | output | 1 | Register read strobe |
| rf_rdata | input | 32 | Register read data, valid the cycle after rf_rd |

## Verification
Writes of one and several words are followed by reads of the same words. These show whether packing, address stepping and response byte order agree. Error cases are run one at a time: an odd address, an odd count, a range that contains a read-only word past its first word, too few and too many data bytes, and a range past the end. Each case shows which rule fires. It also shows whether any word leaked out before the rejection. Event pulses on each status bit, and a clear that lands in the same cycle as an event, show the set and clear order of the status byte. Zero-length requests show that an empty transfer is silent.

// File: rtl/reg_access_status.sv
module reg_access_status #(
  parameter int NREGS = 32,
  parameter logic [NREGS-1:0] RO_MASK = {4'hF, {(NREGS-5){1'b0}}, 1'b1}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_start,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_len,
  input  logic        wdat_valid,
  input  logic [7:0]  wdat_byte,
  input  logic        req_done,
  input  logic [7:0]  evt_in,
  input  logic        stat_rd,
  output logic [7:0]  status,
  output logic        rsp_valid,
  output logic [7:0]  rsp_byte,
  output logic [15:0] rf_addr,
  output logic [31:0] rf_wdata,
  output logic        rf_we,
  output logic        rf_rd,
  input  logic [31:0] rf_rdata
);
  localparam int IW   = $clog2(NREGS);
  localparam int CW   = IW + 2;
  localparam int MAXB = NREGS * 4;

  typedef enum logic [2:0] {S_IDLE, S_COLL, S_WR, S_RDREQ, S_RDCAP, S_RDOUT} st_t;

  st_t          st;
  logic [15:0]  base, len, cnt;
  logic [IW:0]  nw, k;
  logic [1:0]   b;
  logic [31:0]  word;
  logic [7:0]   dbuf [MAXB];
  logic         ro_hit, bad_hdr, own_err, last_k;
  logic [16:0]  end_b;
  logic [CW-1:0] bi;

  assign end_b = {1'b0, req_addr} + {1'b0, req_len};

  always_comb begin
    ro_hit = 1'b0;
    for (int i = 0; i < NREGS; i++)
      if (RO_MASK[i] && 17'(i * 4) >= {1'b0, req_addr} && 17'(i * 4) < end_b)
        ro_hit = 1'b1;
  end

  assign bad_hdr = (|req_addr[1:0]) | (|req_len[1:0]) | (end_b > 17'(MAXB)) | (req_write & ro_hit);
  assign own_err = (st == S_IDLE && req_start && bad_hdr) ||
                   (st == S_COLL && req_done && cnt != len);
  assign last_k  = (k == nw - (IW+1)'(1));
  assign bi      = {k[IW-1:0], 2'b00};

  assign rf_addr   = base + 16'({k, 2'b00});
  assign rf_we     = (st == S_WR);
  assign rf_rd     = (st == S_RDREQ);
  assign rf_wdata  = {dbuf[bi], dbuf[bi + CW'(1)], dbuf[bi + CW'(2)], dbuf[bi + CW'(3)]};
  assign rsp_valid = (st == S_RDOUT);
  assign rsp_byte  = word[31:24];

  always_ff @(posedge clk) begin
    if (!rst_n) status <= 8'h00;
    else        status <= (stat_rd ? 8'h00 : status) | evt_in | {4'b0, own_err, 3'b0};
  end

  always_ff @(posedge clk) begin
    if (st == S_COLL && wdat_valid && cnt < 16'(MAXB))
      dbuf[cnt[CW-1:0]] <= wdat_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; base <= '0; len <= '0; cnt <= '0;
      nw <= '0; k <= '0; b <= '0; word <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_start && !bad_hdr) begin
          base <= req_addr; len <= req_len; cnt <= '0; k <= '0;
          nw   <= req_len[CW:2];
          if (req_write)           st <= S_COLL;
          else if (req_len != '0)  st <= S_RDREQ;
        end
        S_COLL: begin
          if (wdat_valid) cnt <= cnt + 16'd1;
          if (req_done)   st  <= (cnt != len || len == '0) ? S_IDLE : S_WR;
        end
        S_WR: begin
          k <= k + (IW+1)'(1);
          if (last_k) st <= S_IDLE;
        end
        S_RDREQ: st <= S_RDCAP;
        S_RDCAP: begin word <= rf_rdata; b <= '0; st <= S_RDOUT; end
        S_RDOUT: begin
          word <= word << 8;
          b    <= b + 2'd1;
          if (b == 2'd3) begin
            k  <= k + (IW+1)'(1);
            st <= last_k ? S_IDLE : S_RDREQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module reg_access_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  evt_in,
  input logic        stat_rd,
  input logic [7:0]  status,
  input logic        rf_we,
  input logic        rf_rd,
  input logic        rsp_valid,
  input logic [15:0] rf_addr
);
  assert_evt_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_in) |=> ((status & $past(evt_in)) == $past(evt_in)));
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && evt_in == 8'h00) |=> ((status & 8'hF7) == 8'h00));
  assert_keep_on_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && |evt_in) |=> ((status & $past(evt_in)) != 8'h00));
  assert_we_rd_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (!rf_rd && !rsp_valid));
  assert_rd_rsp_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd |-> !rsp_valid);
  assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && $past(rf_we)) |-> (rf_addr == $past(rf_addr) + 16'd4));
  assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we || rf_rd) |-> (rf_addr[1:0] == 2'b00));
endmodule

bind reg_access_status reg_access_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .stat_rd(stat_rd), .status(status),
  .rf_we(rf_we), .rf_rd(rf_rd), .rsp_valid(rsp_valid), .rf_addr(rf_addr)
);

// File: tb/sim_reg_access_status.sv
module sim_reg_access_status;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 32;

  logic clk = 0, rst_n = 0;
  logic req_start = 0, req_write = 0, wdat_valid = 0, req_done = 0, stat_rd = 0;
  logic [15:0] req_addr = 0, req_len = 0;
  logic [7:0]  wdat_byte = 0, evt_in = 0;
  logic [7:0]  status, rsp_byte;
  logic        rsp_valid, rf_we, rf_rd;
  logic [15:0] rf_addr;
  logic [31:0] rf_wdata, rf_rdata;

  int vectors = 0, fails = 0, cycles = 0;
  string cur_req = "R8";

  logic [31:0] mem [NR];
  logic [47:0] exp_wr[$];
  logic [7:0]  exp_rsp[$];
  logic [7:0]  m_data[$];
  logic [7:0]  exp_st;
  bit          m_coll;
  int          m_addr, m_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_access_status u0 (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .wdat_valid(wdat_valid), .wdat_byte(wdat_byte),
    .req_done(req_done), .evt_in(evt_in), .stat_rd(stat_rd), .status(status),
    .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
    .rf_we(rf_we), .rf_rd(rf_rd), .rf_rdata(rf_rdata)
  );

  function automatic bit ro_reg(int r);
    return (r == 0) || (r >= 28);
  endfunction

  function automatic bit bad_req(bit wr, int a, int n);
    if (a % 4 != 0 || n % 4 != 0) return 1;
    if (a + n > NR * 4) return 1;
    if (wr) for (int r = a / 4; r < (a + n) / 4; r++) if (ro_reg(r)) return 1;
    return 0;
  endfunction

  initial for (int i = 0; i < NR; i++) mem[i] = 32'hA500_0000 ^ (i * 32'h0103_0507);

  // register file environment and reference model
  always @(posedge clk) begin
    bit own;
    if (rf_rd) rf_rdata <= mem[rf_addr >> 2];
    if (rf_we) mem[rf_addr >> 2] <= rf_wdata;
    if (!rst_n) begin
      exp_st = 0; m_coll = 0;
    end else begin
      own = 0;
      if (wdat_valid && m_coll) m_data.push_back(wdat_byte);
      if (req_done && m_coll) begin
        m_coll = 0;
        if (m_data.size() != m_len) own = 1;
        else for (int w = 0; w < m_len / 4; w++)
          exp_wr.push_back({16'(m_addr + 4 * w), m_data[4*w], m_data[4*w+1], m_data[4*w+2], m_data[4*w+3]});
      end
      if (req_start) begin
        if (bad_req(req_write, req_addr, req_len)) own = 1;
        else if (req_write) begin
          m_coll = 1; m_addr = req_addr; m_len = req_len; m_data.delete();
        end else
          for (int w = 0; w < req_len / 4; w++)
            for (int s = 3; s >= 0; s--) exp_rsp.push_back(8'(mem[req_addr / 4 + w] >> (8 * s)));
      end
      exp_st = (stat_rd ? 8'h00 : exp_st) | evt_in | (own ? 8'h08 : 8'h00);
    end
  end

  always @(negedge clk) begin
    logic [47:0] e;
    cycles++;
    if (rst_n) begin
      vectors++;
      if (status !== exp_st) begin
        fails++; $display("FAIL %s status actual %02h expected %02h", cur_req, status, exp_st);
      end
      if (rf_we && rf_rd) begin
        fails++; $display("FAIL R12 we/rd overlap actual 1 expected 0");
      end
      if (rf_we) begin
        vectors++;
        if (exp_wr.size() == 0) begin
          fails++; $display("FAIL %s write actual %04h:%08h expected none", cur_req, rf_addr, rf_wdata);
        end else begin
          e = exp_wr.pop_front();
          if ({rf_addr, rf_wdata} !== e) begin
            fails++; $display("FAIL R7 write actual %04h:%08h expected %04h:%08h", rf_addr, rf_wdata, e[47:32], e[31:0]);
          end
        end
      end
      if (rsp_valid) begin
        vectors++;
        if (exp_rsp.size() == 0) begin
          fails++; $display("FAIL %s response actual %02h expected none", cur_req, rsp_byte);
        end else if (rsp_byte !== exp_rsp[0]) begin
          fails++; $display("FAIL R1 response actual %02h expected %02h", rsp_byte, exp_rsp[0]);
          void'(exp_rsp.pop_front());
        end else void'(exp_rsp.pop_front());
      end
    end
    if (cycles > 100000) begin
      fails++; $display("FAIL watchdog actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request(bit wr, int a, int n, int nbytes, int seed);
    @(negedge clk);
    req_start = 1; req_write = wr; req_addr = 16'(a); req_len = 16'(n);
    @(negedge clk);
    req_start = 0;
    if (wr) begin
      for (int i = 0; i < nbytes; i++) begin
        wdat_valid = 1; wdat_byte = 8'(seed + 17 * i);
        @(negedge clk);
      end
      wdat_valid = 0; req_done = 1;
      @(negedge clk);
      req_done = 0;
    end
    idle(n / 4 * 7 + 6);
  endtask

  task automatic read_status(logic [7:0] ev);
    @(negedge clk);
    stat_rd = 1; evt_in = ev;
    @(negedge clk);
    stat_rd = 0; evt_in = 0;
    idle(2);
  endtask

  task automatic queues_empty();
    vectors++;
    if (exp_wr.size() != 0 || exp_rsp.size() != 0) begin
      fails++;
      $display("FAIL %s pending actual %0d/%0d expected 0/0", cur_req, exp_wr.size(), exp_rsp.size());
      exp_wr.delete(); exp_rsp.delete();
    end
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    cur_req = "R7"; request(1, 8, 8, 8, 8'h31); queues_empty();
    request(1, 4, 4, 4, 8'hDE); queues_empty();
    cur_req = "R1"; request(0, 4, 12, 0, 0); queues_empty();
    request(0, 64, 12, 0, 0); queues_empty();
    cur_req = "R2"; request(1, 6, 4, 4, 8'h11); queues_empty();
    cur_req = "R9"; read_status(8'h00);
    cur_req = "R2"; request(0, 2, 8, 0, 0); queues_empty();
    cur_req = "R3"; request(0, 16, 6, 0, 0); queues_empty();
    request(1, 16, 6, 6, 8'h22); queues_empty();
    cur_req = "R9"; read_status(8'h00);
    cur_req = "R4"; request(1, 104, 24, 24, 8'h40); queues_empty();
    request(1, 0, 8, 8, 8'h50); queues_empty();
    cur_req = "R9"; read_status(8'h00);
    cur_req = "R5"; request(1, 32, 8, 7, 8'h60); queues_empty();
    cur_req = "R9"; read_status(8'h00);
    cur_req = "R5"; request(1, 32, 8, 9, 8'h70); queues_empty();
    cur_req = "R6"; request(0, 124, 8, 0, 0); queues_empty();
    request(1, 96, 64, 64, 8'h05); queues_empty();
    cur_req = "R9"; read_status(8'h00);
    cur_req = "R11"; request(1, 20, 0, 0, 0); queues_empty();
    request(0, 20, 0, 0, 0); queues_empty();
    cur_req = "R8";
    for (int bit_i = 0; bit_i < 8; bit_i++) begin
      @(negedge clk); evt_in = 8'(1 << bit_i);
      @(negedge clk); evt_in = 0;
    end
    idle(2);
    cur_req = "R10"; read_status(8'h24);
    cur_req = "R9"; read_status(8'h00);
    cur_req = "R1"; request(0, 8, 8, 0, 0); queues_empty();
    idle(5);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule